// File: doc/BRIEF.md
# Supply Warning Flags and Reset-Cause Controller

This block holds the digital status and interrupt state of a power management unit. Two analog comparators watch two supplies: a main regulated rail and a reference rail. Each comparator delivers an asynchronous digital level, which the block synchronizes. A third asynchronous level reports that a low-voltage reset has been applied. For each rail the block keeps a sticky warning flag and an interrupt enable. Software clears a warning flag by writing 1 to an acknowledge bit that belongs to that rail. It does not write the flag itself. One reset-cause flag records that the last reset came from a low supply or from power-up. Other system resets leave it alone. A 2-bit field selects the threshold of the reference-rail comparator.

Software reaches the block through a small register port. A write is a single-cycle strobe. A read is a single-cycle strobe that returns its word one clock later, together with a valid pulse. The port has no back-pressure: every strobe is accepted in the cycle it is seen. While the reduced-performance input is high, no comparator can set any flag. The flags already set stay as they are. A single registered interrupt line combines both rails.

Register map (address: bits): 0 main rail, 1 reference rail: bit 0 flag (read-only), bit 1 interrupt enable, bit 2 acknowledge (write-one, reads 0); 2 threshold: bits [1:0]; 3 reset cause: bit 0 flag (write 1 clears). Unused bits read 0.

Top module: `lvw_status_ctrl`

## Requirements
- R1: A main-rail comparator level that is active, after two synchronizer flops, sets the main flag (address 0, bit 0) on the next clock unless reduced-performance mode is on. The flag stays 1 after the comparator returns low.
- R2: `irq` is a register that takes the OR over both rails of flag AND enable. It follows a change of flag or enable one clock later.
- R3: Writing 1 to bit 2 of a rail's register clears that rail's flag. Writing 0 there has no effect. Bit 2 always reads 0.
- R4: If a rail's synchronized comparator level is still active when its acknowledge is written, the set wins and the flag stays 1.
- R5: The reference rail (address 1) has its own flag, enable and acknowledge. Activity on one rail never changes the other rail's flag or enable.
- R6: Address 2 bits [1:0] hold the reference threshold select and drive `thresh_sel`. Its other bits are ignored and read 0.
- R7: While `rpm` is 1, no comparator input (main, reference or low-voltage reset) can set any flag.
- R8: The reset-cause flag (address 3, bit 0) is 1 after `por_n` and is set by a synchronized `lvr_req`. Writing 1 clears it. `rst_n` does not change it.
- R9: `rst_n` low clears both rail flags, both enables and the threshold field.
- R10: A read strobe gives `rd_valid` high with the addressed word on `rdata` on the next clock. With no read strobe, `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| rpm | input | 1 | Reduced-performance mode; blocks all flag setting |
| cmp_main | input | 1 | Asynchronous main-rail low-voltage level |
| cmp_ref | input | 1 | Asynchronous reference-rail low-voltage level |
| lvr_req | input | 1 | Asynchronous low-voltage reset indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |
| thresh_sel | output | THR_W | Reference comparator threshold select |
| irq | output | 1 | Combined warning interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit data word, two synchronizer stages and a 2-bit threshold. With these values the three-clock path from comparator to flag, and the one further clock to the interrupt, have fixed cycle counts that the bench can check. The 8-bit word also carries write data above the used fields, so the bench can show that those bits are ignored. The defaults also let the bench drive acknowledge collisions while the comparator is still active, and keep comparators active across reduced-performance mode. They also let it apply the two resets separately, so the reset-cause flag can be seen to survive one of them and not the other.

// File: rtl/lvw_pkg.sv
package lvw_pkg;
  localparam int ADDR_W   = 2;
  localparam int NUM_RAIL = 2;
  localparam int FLAG_BIT = 0;
  localparam int IE_BIT   = 1;
  localparam int ACK_BIT  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MAIN  = 2'd0,
    A_REF   = 2'd1,
    A_THR   = 2'd2,
    A_CAUSE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lvw_sync.sv
module lvw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lvw_rail_flag.sv
module lvw_rail_flag (
  input  logic clk,
  input  logic arst_n,
  input  logic hit,
  input  logic block,
  input  logic reg_wr,
  input  logic ie_bit,
  input  logic ack_bit,
  output logic flag,
  output logic ie
);
  logic set_now;
  assign set_now = hit && !block;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (set_now)               flag <= 1'b1;
      else if (reg_wr && ack_bit) flag <= 1'b0;
      if (reg_wr) ie <= ie_bit;
    end
  end
endmodule

// File: rtl/lvw_cause_flag.sv
module lvw_cause_flag (
  input  logic clk,
  input  logic por_n,
  input  logic hit,
  input  logic block,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              flag <= 1'b1;
    else if (hit && !block)  flag <= 1'b1;
    else if (clr)            flag <= 1'b0;
  end
endmodule

// File: rtl/lvw_status_ctrl.sv
module lvw_status_ctrl
  import lvw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              rpm,
  input  logic              cmp_main,
  input  logic              cmp_ref,
  input  logic              lvr_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic [THR_W-1:0]  thresh_sel,
  output logic              irq
);
  localparam int USED_W = (ACK_BIT + 1 > THR_W) ? ACK_BIT + 1 : THR_W;

  logic                sys_rst_n;
  logic [NUM_RAIL-1:0] cmp_raw;
  logic [NUM_RAIL-1:0] ch_hit;
  logic [NUM_RAIL-1:0] ch_wr;
  logic [NUM_RAIL-1:0] flag;
  logic [NUM_RAIL-1:0] ie;
  logic                lvr_hit;
  logic                lvr_flag;
  logic                cause_clr;
  logic [THR_W-1:0]    thr_q;
  logic [DATA_W-1:0]   rd_word;
  logic                unused_wbits;

  assign sys_rst_n    = rst_n & por_n;
  assign cmp_raw      = {cmp_ref, cmp_main};
  assign unused_wbits = ^wdata[DATA_W-1:USED_W];

  lvw_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_RAIL)) rail_sync_i (
    .clk(clk), .arst_n(sys_rst_n), .async_in(cmp_raw), .sync_out(ch_hit)
  );

  lvw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) lvr_sync_i (
    .clk(clk), .arst_n(por_n), .async_in(lvr_req), .sync_out(lvr_hit)
  );

  for (genvar i = 0; i < NUM_RAIL; i++) begin : g_rail
    assign ch_wr[i] = wr_en && (addr == ADDR_W'(i));
    lvw_rail_flag rail_i (
      .clk(clk), .arst_n(sys_rst_n), .hit(ch_hit[i]), .block(rpm),
      .reg_wr(ch_wr[i]), .ie_bit(wdata[IE_BIT]), .ack_bit(wdata[ACK_BIT]),
      .flag(flag[i]), .ie(ie[i])
    );
  end

  assign cause_clr = wr_en && (addr == A_CAUSE) && wdata[FLAG_BIT];

  lvw_cause_flag cause_i (
    .clk(clk), .por_n(por_n), .hit(lvr_hit), .block(rpm),
    .clr(cause_clr), .flag(lvr_flag)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) thr_q <= '0;
    else if (wr_en && addr == A_THR) thr_q <= wdata[THR_W-1:0];
  end
  assign thresh_sel = thr_q;

  always_comb begin
    rd_word = '0;
    case (addr)
      A_MAIN: begin
        rd_word[FLAG_BIT] = flag[0];
        rd_word[IE_BIT]   = ie[0];
      end
      A_REF: begin
        rd_word[FLAG_BIT] = flag[1];
        rd_word[IE_BIT]   = ie[1];
      end
      A_THR:   rd_word[THR_W-1:0] = thr_q;
      default: rd_word[FLAG_BIT]  = lvr_flag;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
      irq <= |(flag & ie);
    end
  end
endmodule

// File: rtl/lvw_status_ctrl_chk.sv
module lvw_status_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              rpm,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic [1:0]        ch_hit,
  input logic [1:0]        flag,
  input logic [1:0]        ie,
  input logic              lvr_hit,
  input logic              lvr_flag,
  input logic              irq
);
  p_set_sticky_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    flag[0] && !(wr_en && addr == 2'd0 && wdata[2]) |=> flag[0]);

  p_irq_lag_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((flag & ie) == 2'b00) |=> !irq);

  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (wr_en && addr == 2'd0 && wdata[2] && !(ch_hit[0] && !rpm)) |=> !flag[0]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (ch_hit[0] && !rpm) |=> flag[0]);

  p_ref_set_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (ch_hit[1] && !rpm) |=> flag[1]);

  p_rpm_no_set_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rpm |=> ((flag & ~$past(flag)) == 2'b00));

  p_rpm_no_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
    (rpm && !lvr_flag) |=> !lvr_flag);

  p_cause_set_r8: assert property (@(posedge clk) disable iff (!por_n)
    (lvr_hit && !rpm) |=> lvr_flag);

  p_read_valid_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rd_en |=> rd_valid);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind lvw_status_ctrl lvw_status_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .rpm(rpm),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rd_valid(rd_valid), .ch_hit(ch_hit), .flag(flag), .ie(ie),
  .lvr_hit(lvr_hit), .lvr_flag(lvr_flag), .irq(irq)
);

// File: tb/lvw_status_ctrl_tb_top.sv
module lvw_status_ctrl_tb_top;
  localparam int DATA_W = 8;
  localparam int THR_W  = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, rpm = 1'b0;
  logic cmp_main = 1'b0, cmp_ref = 1'b0, lvr_req = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic rd_valid;
  logic [THR_W-1:0] thresh_sel;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #10 clk = ~clk;

  lvw_status_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(2), .THR_W(THR_W)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .rpm(rpm),
    .cmp_main(cmp_main), .cmp_ref(cmp_ref), .lvr_req(lvr_req),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .thresh_sel(thresh_sel), .irq(irq)
  );

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (rd_valid) begin
      if (sb_q.size() == 0) begin
        check(rdata, '1, "R10 unexpected read data");
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    idle(2);
    por_n = 1'b1; rst_n = 1'b1;
    idle(2);
    // reset state
    check({7'd0, irq}, 8'h00, "R2 reset irq");
    check({6'd0, thresh_sel}, 8'h00, "R9 reset threshold pin");
    check({7'd0, rd_valid}, 8'h00, "R10 idle rd_valid");
    reg_rd(2'd0, 8'h00, "R9 reset main reg");
    reg_rd(2'd1, 8'h00, "R9 reset ref reg");
    reg_rd(2'd2, 8'h00, "R6 reset threshold reg");
    reg_rd(2'd3, 8'h01, "R8 cause flag after power-on");
    reg_wr(2'd3, 8'h01);
    reg_rd(2'd3, 8'h00, "R8 cause flag cleared by write 1");

    // main rail sets, sticky, no irq without enable
    @(negedge clk); cmp_main = 1'b1;
    idle(4); cmp_main = 1'b0;
    idle(3);
    reg_rd(2'd0, 8'h01, "R1 main flag sticky");
    reg_rd(2'd1, 8'h00, "R5 ref untouched by main");
    check({7'd0, irq}, 8'h00, "R2 irq masked");

    // enable with ack=0
    reg_wr(2'd0, 8'h02);
    idle(1);
    check({7'd0, irq}, 8'h01, "R2 irq after enable");
    reg_rd(2'd0, 8'h03, "R3 ack 0 no effect");

    // ack while condition active
    @(negedge clk); cmp_main = 1'b1;
    idle(4);
    reg_wr(2'd0, 8'h06);
    reg_rd(2'd0, 8'h03, "R4 set wins over ack");
    check({7'd0, irq}, 8'h01, "R4 irq held");
    cmp_main = 1'b0;
    idle(3);
    reg_wr(2'd0, 8'h06);
    reg_rd(2'd0, 8'h02, "R3 ack clears, ack reads 0");
    check({7'd0, irq}, 8'h00, "R2 irq drops after clear");

    // reference rail
    reg_wr(2'd1, 8'h02);
    @(negedge clk); cmp_ref = 1'b1;
    idle(4); cmp_ref = 1'b0;
    idle(3);
    reg_rd(2'd1, 8'h03, "R5 ref flag set");
    reg_rd(2'd0, 8'h02, "R5 main untouched by ref");
    check({7'd0, irq}, 8'h01, "R2 irq from ref");
    reg_wr(2'd1, 8'h04);
    reg_rd(2'd1, 8'h00, "R5 ref ack clears");
    check({7'd0, irq}, 8'h00, "R2 irq after ref clear");

    // threshold field
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd2, 8'h03, "R6 threshold upper bits ignored");
    check({6'd0, thresh_sel}, 8'h03, "R6 threshold pin 3");
    reg_wr(2'd2, 8'h01);
    check({6'd0, thresh_sel}, 8'h01, "R6 threshold pin 1");

    // reduced-performance mode blocks setting
    @(negedge clk); rpm = 1'b1;
    cmp_main = 1'b1; cmp_ref = 1'b1; lvr_req = 1'b1;
    idle(6);
    reg_rd(2'd0, 8'h02, "R7 main blocked in rpm");
    reg_rd(2'd1, 8'h00, "R7 ref blocked in rpm");
    reg_rd(2'd3, 8'h00, "R7 cause blocked in rpm");
    cmp_main = 1'b0; cmp_ref = 1'b0; lvr_req = 1'b0;
    idle(4);
    rpm = 1'b0;
    idle(2);
    reg_rd(2'd0, 8'h02, "R7 no late set after rpm");

    // low-voltage reset indication
    @(negedge clk); lvr_req = 1'b1;
    idle(4); lvr_req = 1'b0;
    idle(3);
    reg_rd(2'd3, 8'h01, "R8 cause set by lvr");

    // system reset keeps cause flag, clears the rest
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    idle(1);
    check({6'd0, thresh_sel}, 8'h00, "R9 threshold cleared by rst_n");
    reg_rd(2'd0, 8'h00, "R9 main cleared by rst_n");
    reg_rd(2'd3, 8'h01, "R8 cause kept over rst_n");

    // power-on reset sets cause flag
    reg_wr(2'd3, 8'h01);
    reg_rd(2'd3, 8'h00, "R8 cause cleared again");
    @(negedge clk); por_n = 1'b0;
    idle(2); por_n = 1'b1;
    idle(1);
    reg_rd(2'd3, 8'h01, "R8 cause set by power-on");
    idle(2);
    check({7'd0, rd_valid}, 8'h00, "R10 no read, no valid");
    check(8'(sb_q.size()), 8'h00, "R10 all reads answered");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule